// File: doc/BRIEF.md
# Flash Program/Erase Status Reporter

This block wraps a small behavioural word array and reports the progress of an internal program or erase operation the way a word-wide flash part reports it on its data bus. A one-cycle start request carries an operation type, a target address and a data word. The block then counts the operation's duration in clock cycles and commits the result to the array when the count runs out. The result is a word program, or an erase of a page, a block or the whole array.

While the operation runs, an array read returns a status word instead of array contents. Bit 7 is a polling bit and bit 6 flips on every new read. A separate open-drain style flag is pulled low for as long as the operation lasts. A functional halt input stops a running operation without committing it, and it releases the data bus. Once the operation ends, reads return array data again without any command from the host.

Top module: `flash_op_status`

## Requirements
- R1: After the synchronous reset (rst_n low at a clock edge) no operation is running, rdy_pull_low is 0 and every array word reads 0xFFFF.
- R2: A start accepted while idle keeps rdy_pull_low high for exactly T_PROG, T_PAGE, T_BLOCK or T_CHIP cycles, selected by op_type encoding 0 = word program, 1 = page erase, 2 = block erase, 3 = chip erase.
- R3: rdy_pull_low is 1 from the clock edge that accepts a start until the edge that completes or halts the operation, and 0 at all other times.
- R4: During a word program, an enabled read at any address returns bit 7 equal to the complement of bit 7 of the programmed data, and every bit other than 7 and 6 reads 0.
- R5: During any erase, bit 7 of an enabled read is 0.
- R6: During an operation, bit 6 of the read word flips once for each new read (a rising edge of ce_n and oe_n both low). A read that is held does not flip it, and reads while idle do not flip it.
- R7: A completed word program stores the old word AND the programmed data, so bits can only go from 1 to 0.
- R8: A completed erase sets to 0xFFFF every word in the target region and leaves all other words alone. A page is the aligned group of 2^PAGE_AW words that holds addr, a block is the aligned group of 2^BLOCK_AW words, and a chip erase covers every word.
- R9: Once an operation completes, reads return the stored array word again with no further command.
- R10: A start request while an operation is running is ignored: the running duration is not extended and the second request's data is never applied.
- R11: halt_n low at a clock edge ends a running operation without committing it and releases rdy_pull_low. While halt_n is low, dq_en is 0.
- R12: dq_en is 1 only when ce_n and oe_n are both low and halt_n is high. rd_data is 0 whenever dq_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_n | input | 1 | Functional halt, active low; aborts the running operation |
| start | input | 1 | One-cycle request to begin an operation |
| op_type | input | 2 | Operation: 0 program, 1 page erase, 2 block erase, 3 chip erase |
| addr | input | AW | Target address for a start; read address otherwise |
| wdata | input | DW | Data word for a program |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | DW | Read word: array data when idle, status while busy |
| dq_en | output | 1 | High when rd_data is driven onto the bus |
| rdy_pull_low | output | 1 | High while the ready line is pulled low (busy) |

## Verification
The bench builds the block with a 64-word array of 16-bit words, 4-word pages and 16-word blocks. Durations are 6, 8, 10 and 12 cycles. At these sizes every operation type can be timed edge by edge and two reads fit inside even the shortest program. After every erase and after the halt, all 64 words are read back and compared with an arithmetic model of page and block alignment. This covers page and block edges, words outside the region, the 1-to-0 rule on repeated programs, and the toggle count carried across idle reads.

// File: rtl/flash_status_pkg.sv
// Shared operation encoding for the flash status reporter.
package flash_status_pkg;
    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_PAGE  = 2'd1,
        OP_BLOCK = 2'd2,
        OP_CHIP  = 2'd3
    } flash_op_e;
endpackage

// File: rtl/flash_op_timer.sv
// Operation sequencer: accepts a start while idle and latches the operation,
// address and data. It counts the selected duration down and pulses 'done'
// on the last busy cycle. Assumes every duration parameter is at least 1.
// A low halt_n ends the operation with no commit.
module flash_op_timer
    import flash_status_pkg::*;
#(
    parameter int AW      = 6,
    parameter int DW      = 16,
    parameter int T_PROG  = 6,
    parameter int T_PAGE  = 8,
    parameter int T_BLOCK = 10,
    parameter int T_CHIP  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt_n,
    input  logic          start,
    input  flash_op_e     op_type,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output flash_op_e     op_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    localparam int T_MAX1 = (T_PROG > T_PAGE) ? T_PROG : T_PAGE;
    localparam int T_MAX2 = (T_BLOCK > T_CHIP) ? T_BLOCK : T_CHIP;
    localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dur_sel;
    logic             accept;

    // Pick the duration of the requested operation.
    always_comb begin
        case (op_type)
            OP_PROG:  dur_sel = CNT_W'(T_PROG);
            OP_PAGE:  dur_sel = CNT_W'(T_PAGE);
            OP_BLOCK: dur_sel = CNT_W'(T_BLOCK);
            default:  dur_sel = CNT_W'(T_CHIP);
        endcase
    end

    assign accept = start && !busy && halt_n;
    assign done   = busy && halt_n && (cnt == CNT_W'(1));

    // Start, count down, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
        end else if (!halt_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            busy   <= 1'b1;
            cnt    <= dur_sel;
            op_q   <= op_type;
            addr_q <= addr;
            data_q <= wdata;
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/flash_word_array.sv
// Behavioural word array. On 'commit' it applies the latched operation:
// a program ANDs the data into one word, and an erase sets every word of
// the aligned page, block or whole array to all ones. Assumes
// PAGE_AW <= BLOCK_AW < AW. Reset fills the array with ones.
module flash_word_array
    import flash_status_pkg::*;
#(
    parameter int AW       = 6,
    parameter int DW       = 16,
    parameter int PAGE_AW  = 2,
    parameter int BLOCK_AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  flash_op_e     op,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        localparam logic [AW-1:0] IA = AW'(i);
        // Decide whether word i lies in the target region.
        always_comb begin
            case (op)
                OP_PROG:  hit[i] = (tgt_addr == IA);
                OP_PAGE:  hit[i] = (tgt_addr[AW-1:PAGE_AW] == IA[AW-1:PAGE_AW]);
                OP_BLOCK: hit[i] = (tgt_addr[AW-1:BLOCK_AW] == IA[AW-1:BLOCK_AW]);
                default:  hit[i] = 1'b1;
            endcase
        end
    end

    // Apply the committed operation to every selected word.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= '1;
            end else if (commit && hit[i]) begin
                mem[i] <= (op == OP_PROG) ? (mem[i] & tgt_data) : '1;
            end
        end
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/flash_status_mux.sv
// Read path: gates the bus with the read strobe and halt, and keeps the
// toggle bit, which flips on each rising read strobe while busy. It returns
// either the array word or the status word. Assumes DW >= 8.
module flash_status_mux
    import flash_status_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          busy,
    input  flash_op_e     op_q,
    input  logic          prog_bit7,
    input  logic [DW-1:0] arr_word,
    output logic          dq_en,
    output logic [DW-1:0] rd_data
);
    logic          strobe;
    logic          strobe_q;
    logic          tog_q;
    logic [DW-1:0] status;

    assign strobe = !ce_n && !oe_n && halt_n;
    assign dq_en  = strobe;

    // Remember the strobe and flip the toggle bit on each new busy read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            tog_q    <= 1'b0;
        end else begin
            strobe_q <= strobe;
            if (busy && strobe && !strobe_q) begin
                tog_q <= ~tog_q;
            end
        end
    end

    // Build the status word shown while an operation runs.
    always_comb begin
        status    = '0;
        status[7] = (op_q == OP_PROG) ? ~prog_bit7 : 1'b0;
        status[6] = tog_q;
    end

    // Select what goes onto the bus.
    always_comb begin
        if (!dq_en) begin
            rd_data = '0;
        end else if (busy) begin
            rd_data = status;
        end else begin
            rd_data = arr_word;
        end
    end
endmodule

// File: rtl/flash_op_status.sv
// Top level of the flash program/erase status reporter. It ties the
// sequencer, the array and the read path together. The ready line is
// modelled as a pull-low request that is high while busy. Assumes the
// host holds addr steady during a read.
module flash_op_status
    import flash_status_pkg::*;
#(
    parameter int AW       = 6,
    parameter int DW       = 16,
    parameter int PAGE_AW  = 2,
    parameter int BLOCK_AW = 4,
    parameter int T_PROG   = 6,
    parameter int T_PAGE   = 8,
    parameter int T_BLOCK  = 10,
    parameter int T_CHIP   = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          halt_n,
    input  logic          start,
    input  logic [1:0]    op_type,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          ce_n,
    input  logic          oe_n,
    output logic [DW-1:0] rd_data,
    output logic          dq_en,
    output logic          rdy_pull_low
);
    logic          busy;
    logic          done;
    flash_op_e     cur_op;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;
    logic [DW-1:0] arr_word;

    flash_op_timer #(
        .AW(AW), .DW(DW),
        .T_PROG(T_PROG), .T_PAGE(T_PAGE), .T_BLOCK(T_BLOCK), .T_CHIP(T_CHIP)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .halt_n (halt_n),
        .start  (start),
        .op_type(flash_op_e'(op_type)),
        .addr   (addr),
        .wdata  (wdata),
        .busy   (busy),
        .done   (done),
        .op_q   (cur_op),
        .addr_q (tgt_addr),
        .data_q (tgt_data)
    );

    flash_word_array #(
        .AW(AW), .DW(DW), .PAGE_AW(PAGE_AW), .BLOCK_AW(BLOCK_AW)
    ) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (done),
        .op      (cur_op),
        .tgt_addr(tgt_addr),
        .tgt_data(tgt_data),
        .rd_addr (addr),
        .rd_word (arr_word)
    );

    flash_status_mux #(
        .DW(DW)
    ) i_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_n   (halt_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .busy     (busy),
        .op_q     (cur_op),
        .prog_bit7(tgt_data[7]),
        .arr_word (arr_word),
        .dq_en    (dq_en),
        .rd_data  (rd_data)
    );

    assign rdy_pull_low = busy;
endmodule

// File: rtl/flash_op_status_chk.sv
// Checker for the status reporter; attached to every instance by bind.
module flash_op_status_chk
    import flash_status_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halt_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          dq_en,
    input logic [DW-1:0] rd_data,
    input logic          rdy_pull_low,
    input logic          busy,
    input flash_op_e     cur_op
);
    AST_HALT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_n |=> !rdy_pull_low); // R11

    AST_HALT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_n |-> !dq_en); // R11

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_en |-> (rd_data == '0)); // R12

    AST_DRIVE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_en |-> (!ce_n && !oe_n)); // R12

    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_en && cur_op != OP_PROG) |-> !rd_data[7]); // R5

    AST_STATUS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_en) |-> ((rd_data >> 8) == '0 && rd_data[5:0] == 6'd0)); // R4

    AST_HELD_READ_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && dq_en && $past(dq_en) && $past(dq_en, 2))
        |-> (rd_data[6] == $past(rd_data[6]))); // R6
endmodule

bind flash_op_status flash_op_status_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_flash_op_status.sv
module test_flash_op_status;
    localparam int AW = 6, DW = 16, PAGE_AW = 2, BLOCK_AW = 4;
    localparam int T_PROG = 6, T_PAGE = 8, T_BLOCK = 10, T_CHIP = 12;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, halt_n, start, ce_n, oe_n;
    logic [1:0]    op_type;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rd_data;
    logic          dq_en, rdy_pull_low;

    flash_op_status #(
        .AW(AW), .DW(DW), .PAGE_AW(PAGE_AW), .BLOCK_AW(BLOCK_AW),
        .T_PROG(T_PROG), .T_PAGE(T_PAGE), .T_BLOCK(T_BLOCK), .T_CHIP(T_CHIP)
    ) i_flash_op_status (.*);

    logic [DW-1:0] model [DEPTH];
    int  n_chk = 0, n_fail = 0;
    bit  tog_m = 1'b0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int dur(input int op);
        case (op)
            0: return T_PROG;
            1: return T_PAGE;
            2: return T_BLOCK;
            default: return T_CHIP;
        endcase
    endfunction

    function automatic void apply(input int op, input int a, input logic [DW-1:0] d);
        for (int i = 0; i < DEPTH; i++) begin
            bit h;
            case (op)
                0: h = (i == a);
                1: h = ((i >> PAGE_AW) == (a >> PAGE_AW));
                2: h = ((i >> BLOCK_AW) == (a >> BLOCK_AW));
                default: h = 1'b1;
            endcase
            if (h) model[i] = (op == 0) ? (model[i] & d) : '1;
        end
    endfunction

    // One read; starts and ends at a falling edge.
    task automatic rd(input int a, output logic [DW-1:0] d, output logic en);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
        if (rdy_pull_low) tog_m = ~tog_m;
        @(posedge clk);
        @(negedge clk);
        d = rd_data; en = dq_en;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_array(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            logic [DW-1:0] d; logic en;
            rd(i, d, en);
            chk(en && d == model[i], req, d, model[i]);
        end
    endtask

    task automatic start_op(input int op, input int a, input logic [DW-1:0] d);
        op_type = 2'(op); addr = AW'(a); wdata = d; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (rdy_pull_low && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic timed_op(input int op, input int a, input logic [DW-1:0] d);
        int n;
        start_op(op, a, d);
        chk(rdy_pull_low == 1'b1, "R3", rdy_pull_low, 1);
        wait_idle(n);
        chk(n == dur(op), "R2", n, dur(op));
        chk(rdy_pull_low == 1'b0, "R3", rdy_pull_low, 0);
        apply(op, a, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d, d_prev;
        logic en;
        int n;
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        rst_n = 1'b0; halt_n = 1'b1; start = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
        op_type = '0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(rdy_pull_low == 1'b0, "R1", rdy_pull_low, 0);
        check_array("R1");

        // R12: bus gating
        ce_n = 1'b0; oe_n = 1'b1; #2;
        chk(!dq_en && rd_data == '0, "R12", {dq_en, rd_data}, 0);
        ce_n = 1'b1; oe_n = 1'b0; #2;
        chk(!dq_en && rd_data == '0, "R12", {dq_en, rd_data}, 0);
        oe_n = 1'b1;
        @(negedge clk);

        // R2 R7: program sweep over spread addresses and patterns
        for (int k = 0; k < 12; k++) begin
            timed_op(0, (k * 7 + 1) % DEPTH, DW'((k * 16'h1357) ^ 16'hA5A5));
        end
        timed_op(0, 3, 16'hF0F0);
        timed_op(0, 3, 16'h3C3C);
        rd(3, d, en);
        chk(d == 16'h3030, "R7", d, 16'h3030);
        check_array("R7");

        // R4 R6 R9: status reads during a program
        start_op(0, 9, 16'h0F7F);
        rd(9, d, en);
        chk(d[7] == 1'b1, "R4", d[7], 1);
        chk((d & 16'hFF3F) == 0, "R4", d, 0);
        chk(d[6] == tog_m, "R6", d[6], tog_m);
        d_prev = d;
        rd(9, d, en);
        chk(d[6] == tog_m && d[6] != d_prev[6], "R6", d[6], tog_m);
        wait_idle(n);
        apply(0, 9, 16'h0F7F);
        rd(9, d, en);
        chk(d == model[9], "R9", d, model[9]);
        rd(9, d, en);
        rd(9, d, en);
        chk(d == model[9], "R9", d, model[9]);

        // R4: polling bit complement when data bit 7 is 1
        start_op(0, 40, 16'h00F0);
        rd(40, d, en);
        chk(d[7] == 1'b0, "R4", d[7], 0);
        chk(d[6] == tog_m, "R6", d[6], tog_m);
        wait_idle(n);
        apply(0, 40, 16'h00F0);

        // R5 R8: page erase with status read, then full compare
        start_op(1, 5, '0);
        rd(5, d, en);
        chk(d[7] == 1'b0, "R5", d[7], 0);
        chk(d[6] == tog_m, "R6", d[6], tog_m);
        wait_idle(n);
        apply(1, 5, '0);
        check_array("R8");

        // R2 R8: block erase (timed)
        timed_op(2, 20, '0);
        check_array("R8");

        // R10: second start while busy ignored
        start_op(0, 50, 16'hFF00);
        op_type = 2'd0; addr = AW'(51); wdata = 16'h0000; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_idle(n);
        chk(n == T_PROG - 1, "R10", n, T_PROG - 1);
        apply(0, 50, 16'hFF00);
        rd(51, d, en);
        chk(d == model[51], "R10", d, model[51]);
        rd(50, d, en);
        chk(d == model[50], "R10", d, model[50]);

        // R11: halt during a chip erase
        start_op(3, 0, '0);
        repeat (2) @(negedge clk);
        halt_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(rdy_pull_low == 1'b0, "R11", rdy_pull_low, 0);
        chk(!dq_en && rd_data == '0, "R11", {dq_en, rd_data}, 0);
        halt_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        check_array("R11");

        // R5 R8: full chip erase
        start_op(3, 17, '0);
        rd(17, d, en);
        chk(d[7] == 1'b0, "R5", d[7], 0);
        wait_idle(n);
        chk(n == T_CHIP - 2, "R2", n, T_CHIP - 2);
        apply(3, 17, '0);
        check_array("R8");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule